// File: doc/BRIEF.md
# SPI Slave Register Access Bridge

This block lets an external SPI master read and write the register sets of a two-channel UART. Each transfer is framed by an active-low chip select. The first byte the master sends is a command. It carries the transfer direction, a four-bit register address and a two-bit channel code. For a write, the second byte is the data to store. For a read, the block shifts the addressed register out on the slave output during the second byte.

The serial inputs are brought into the system clock domain through synchronizer stages, and the block finds the serial clock edges in that domain. The system clock must run at least about eight times faster than the serial clock, so a 5 Mbps link needs a core clock of at least 40 MHz. Toward the UART side, the block drives a parallel register bus. A write is a one-cycle strobe with address, channel and data. A read latches the selected register's contents. In this project, each UART channel is a sixteen-entry register-file stub. Each entry resets to a known pattern, so reads have defined values.

Top module: `spi_reg_bridge`

## Requirements
- R1: Transfers use SPI mode 0 and move the most significant bit first. The slave input is taken on each rising serial clock edge while chip select is low. The slave output changes only after a falling serial clock edge, and it is held at every other time.
- R2: The first byte is the command. Bit 7 selects the direction (1 = read, 0 = write). Bits 6:3 hold the register address. Bits 2:1 hold the channel code (00 = channel A, 01 = channel B). Bit 0 has no effect.
- R3: For a write, the second byte is stored in the addressed register of the selected channel once its eighth bit has arrived.
- R4: For a read, the addressed register is sampled after the last command bit, and its eight bits are driven on the slave output during the next eight serial clocks, MSB first.
- R5: A command with channel code 10 or 11 changes no register in either channel, and a read with such a code returns 0x00.
- R6: Raising chip select ends the transfer at once. A write with fewer than eight data bits stores nothing, the bit position restarts at the next transfer, and the slave output is 0 while chip select is high.
- R7: After reset, every register holds (16*channel + address) XOR 0x5A, where channel A is 0 and channel B is 1, and the slave output is 0.
- R8: The two channels are independent: a write to one channel leaves the same address of the other channel unchanged.
- R9: Serial clocks beyond the sixteenth in one transfer are ignored and cause no second write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the master, low when idle |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, 0 when not selected |

## Verification
The bench goes after the off-by-one cases in the bit counter. A write cut short after four data bits must leave the register unchanged. A design that strobed early, or kept the partial count across transfers, would corrupt that register or shift the next command. Extra clocks after a complete write must not cause a second write, which a counter that wraps would do. Reads with channel codes 10 and 11 must return zero and writes with them must touch nothing, or data would leak into channel A or B. The reserved command bit is set on one read to catch decoding that used it as part of the channel or address.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned REG_AW = 4;
   localparam int unsigned CHAN_W = 2;
   localparam int unsigned CNT_W  = $clog2(2 * BYTE_W + 1);

   typedef struct packed {
      logic              rd;
      logic [REG_AW-1:0] addr;
      logic [CHAN_W-1:0] chan;
   } cmd_t;

   function automatic logic [BYTE_W-1:0] reg_init(input int unsigned ch,
                                                  input int unsigned a,
                                                  input logic [BYTE_W-1:0] mask);
      return BYTE_W'(ch * (1 << REG_AW) + a) ^ mask;
   endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
   parameter int unsigned     W       = 3,
   parameter int unsigned     STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin
      assert (STAGES >= 2) else $error("spi_in_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= RST_VAL;
               else        stg[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= RST_VAL;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_slave_fsm.sv
module spi_slave_fsm
   import spi_bridge_pkg::*;
#(
   parameter int unsigned NUM_CHAN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sclk_s,
   input  logic              mosi_s,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              miso,
   output logic              wr_stb,
   output logic [REG_AW-1:0] bus_addr,
   output logic [CHAN_W-1:0] bus_chan,
   output logic [BYTE_W-1:0] bus_wdata
);

   localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(2 * BYTE_W - 1);
   localparam logic [CNT_W-1:0] FULL      = CNT_W'(2 * BYTE_W);

   logic              sclk_prev;
   logic              sclk_rise, sclk_fall;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] rx_sh, tx_sh, rx_word;
   logic              load_pend, miso_q, wr_q, chan_ok_w;
   cmd_t              cmd_q;
   logic [BYTE_W-1:0] wdata_q;

   assign sclk_rise = cs_act &&  sclk_s && !sclk_prev;
   assign sclk_fall = cs_act && !sclk_s &&  sclk_prev;
   assign rx_word   = {rx_sh[BYTE_W-2:0], mosi_s};
   assign chan_ok_w = int'(rx_word[CHAN_W:1]) < NUM_CHAN;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= sclk_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         load_pend <= 1'b0;
         miso_q    <= 1'b0;
         wr_q      <= 1'b0;
         cmd_q     <= '0;
         wdata_q   <= '0;
      end else begin
         wr_q <= 1'b0;
         if (!cs_act) begin
            bit_cnt   <= '0;
            load_pend <= 1'b0;
            miso_q    <= 1'b0;
         end else begin
            if (load_pend) begin
               tx_sh     <= rd_data;
               load_pend <= 1'b0;
            end
            if (sclk_rise && bit_cnt < FULL) begin
               rx_sh   <= rx_word;
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == CMD_LAST) begin
                  cmd_q     <= cmd_t'(rx_word[BYTE_W-1:1]);
                  tx_sh     <= '0;
                  load_pend <= rx_word[BYTE_W-1] && chan_ok_w;
               end
               if (bit_cnt == DATA_LAST && !cmd_q.rd &&
                   int'(cmd_q.chan) < NUM_CHAN) begin
                  wr_q    <= 1'b1;
                  wdata_q <= rx_word;
               end
            end
            if (sclk_fall && bit_cnt > CMD_LAST && bit_cnt < FULL) begin
               miso_q <= tx_sh[BYTE_W-1];
               tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
         end
      end
   end

   assign miso      = miso_q;
   assign wr_stb    = wr_q;
   assign bus_addr  = cmd_q.addr;
   assign bus_chan  = cmd_q.chan;
   assign bus_wdata = wdata_q;

   // R6: slave output and bit position clear while deselected
   p_miso_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !miso_q);
   p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> bit_cnt == '0);
   // R9: counter never passes a full transfer
   p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= FULL);
   // R1: output moves only on a falling serial edge
   p_miso_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && !sclk_fall) |=> $stable(miso_q));
   // R3: write strobe lasts one cycle
   p_wr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |=> !wr_q);

endmodule

// File: rtl/uart_regfile_stub.sv
module uart_regfile_stub
   import spi_bridge_pkg::*;
#(
   parameter int unsigned       CH_ID    = 0,
   parameter logic [BYTE_W-1:0] RST_MASK = 8'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata
);

   localparam int unsigned DEPTH = 1 << REG_AW;

   logic [BYTE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= reg_init(CH_ID, i, RST_MASK);
      end else if (wr_en) begin
         mem[addr] <= wdata;
      end
   end

   assign rdata = mem[addr];

endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge
   import spi_bridge_pkg::*;
#(
   parameter int unsigned       NUM_CHAN    = 2,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [BYTE_W-1:0] RST_MASK    = 8'h5A
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sclk,
   input  logic spi_cs_n,
   input  logic spi_mosi,
   output logic spi_miso
);

   initial begin
      assert (NUM_CHAN >= 1 && NUM_CHAN <= (1 << CHAN_W))
         else $error("spi_reg_bridge: NUM_CHAN out of range");
      assert (1 + REG_AW + CHAN_W + 1 == BYTE_W)
         else $error("spi_reg_bridge: command fields do not fill one byte");
   end

   logic [2:0]        sync_q;
   logic              wr_stb;
   logic [REG_AW-1:0] bus_addr;
   logic [CHAN_W-1:0] bus_chan;
   logic [BYTE_W-1:0] bus_wdata, rd_data;
   logic [BYTE_W-1:0] ch_rdata [NUM_CHAN];
   logic [NUM_CHAN-1:0] ch_wr;

   spi_in_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b010)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_sclk, spi_cs_n, spi_mosi}),
      .q     (sync_q)
   );

   spi_slave_fsm #(
      .NUM_CHAN (NUM_CHAN)
   ) i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_act    (!sync_q[1]),
      .sclk_s    (sync_q[2]),
      .mosi_s    (sync_q[0]),
      .rd_data   (rd_data),
      .miso      (spi_miso),
      .wr_stb    (wr_stb),
      .bus_addr  (bus_addr),
      .bus_chan  (bus_chan),
      .bus_wdata (bus_wdata)
   );

   generate
      for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
         assign ch_wr[c] = wr_stb && (int'(bus_chan) == c);
         uart_regfile_stub #(
            .CH_ID    (c),
            .RST_MASK (RST_MASK)
         ) i_regs (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (ch_wr[c]),
            .addr  (bus_addr),
            .wdata (bus_wdata),
            .rdata (ch_rdata[c])
         );
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int c = 0; c < NUM_CHAN; c++)
         if (int'(bus_chan) == c) rd_data = ch_rdata[c];
   end

   // R5, R8: at most one channel takes any write
   p_one_chan_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_wr));
   // R5: a strobe with an unmapped code reaches no channel
   p_bad_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && int'(bus_chan) >= NUM_CHAN) |-> ch_wr == '0);

endmodule

// File: tb/test_spi_reg_bridge.sv
module test_spi_reg_bridge;

   localparam int HALF = 13;
   localparam int NVEC = 17;
   // {command, write data, expected read data}
   localparam logic [23:0] VEC [NVEC] = '{
      24'h98_00_59, // R2 R4 R7 read A3
      24'h9A_00_49, // R7 read B3
      24'h28_C3_00, // R3 write A5
      24'hA9_00_C3, // R2 read A5, reserved bit set
      24'hAA_00_4F, // R8 read B5
      24'h02_81_00, // R3 write B0
      24'h82_00_81, // R3 read B0
      24'h80_00_5A, // R8 read A0
      24'h3C_FF_00, // R5 write code 10
      24'hB8_00_5D, // R5 read A7
      24'hBA_00_4D, // R5 read B7
      24'h3E_FF_00, // R5 write code 11
      24'hB8_00_5D, // R5 read A7
      24'hBA_00_4D, // R5 read B7
      24'hAE_00_00, // R5 read code 11
      24'h78_3C_00, // R3 write A15
      24'hF8_00_3C  // R1 R4 read A15
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic miso;
   int   n_chk = 0, n_bad = 0;
   bit   done = 1'b0;

   always #4 clk = ~clk;

   spi_reg_bridge i_spi_reg_bridge (
      .clk      (clk),
      .rst_n    (rst_n),
      .spi_sclk (sclk),
      .spi_cs_n (cs_n),
      .spi_mosi (mosi),
      .spi_miso (miso)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // shifts nbits of a 24-bit word (MSB first) and collects the slave output
   task automatic xfer(input logic [23:0] tx, input int nbits, output logic [7:0] rx);
      rx = '0;
      cs_n = 1'b0;
      wait_clk(HALF);
      for (int b = 0; b < nbits; b++) begin
         mosi = tx[23-b];
         wait_clk(HALF);
         if (b >= 8 && b < 16) rx = {rx[6:0], miso};
         sclk = 1'b1;
         wait_clk(HALF);
         sclk = 1'b0;
      end
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(HALF);
   endtask

   initial begin
      logic [7:0] rx;
      wait_clk(5);
      check("R7 miso in reset", {7'd0, miso}, 8'h00);
      rst_n = 1'b1;
      wait_clk(5);
      check("R7 miso after reset", {7'd0, miso}, 8'h00);

      for (int v = 0; v < NVEC; v++) begin
         xfer({VEC[v][23:8], 8'h00}, 16, rx);
         if (VEC[v][23]) check($sformatf("R4 vector %0d", v), rx, VEC[v][7:0]);
      end

      // R6: write to A1 cut after four data bits, then read back
      xfer({8'h08, 8'hF0, 8'h00}, 12, rx);
      check("R6 miso deselected", {7'd0, miso}, 8'h00);
      xfer({8'h88, 16'h0}, 16, rx);
      check("R6 aborted write", rx, 8'h5B);
      // R6: read aborted mid-byte, then a full read must line up
      xfer({8'h98, 16'h0}, 11, rx);
      xfer({8'h98, 16'h0}, 16, rx);
      check("R6 realigned read", rx, 8'h59);

      // R9: 24 clocks on a write to A2
      xfer({8'h10, 8'h11, 8'hEE}, 24, rx);
      xfer({8'h90, 16'h0}, 16, rx);
      check("R9 first byte kept", rx, 8'h11);
      xfer({8'h98, 16'h0}, 16, rx);
      check("R9 neighbour untouched", rx, 8'h59);

      // R7: reset restores written registers
      rst_n = 1'b0;
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(5);
      xfer({8'hA8, 16'h0}, 16, rx);
      check("R7 A5 after reset", rx, 8'h5F);
      xfer({8'h82, 16'h0}, 16, rx);
      check("R7 B0 after reset", rx, 8'h4A);
      done = 1'b1;
   end

   initial begin
      for (int t = 0; t < 150000 && !done; t++) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule